// File: doc/BRIEF.md
# Peripheral clock gating and disable control

This block governs the clock and register access of eight peripheral modules. A central disable register carries one bit per module. When a module's bit is set, its clock enable drops, its functional enable drops, its control register returns to its reset value and stays there, and bus accesses to that control register are blocked: writes are dropped and reads return zero. This is the hard disable. A module is enabled again by clearing the bit, and it then starts from its reset state.

Each module also has its own control register. Its run bit is a soft disable: clearing it stops the module's function, but the clock keeps running and the register stays readable and writable. Its idle-stop bit ties the module to the device idle input. While idle is high, a module with that bit set loses both enables. All other modules keep running through idle. Some modules have no run bit. A parameter mask names them, and for those modules the functional enable simply follows the clock enable.

Software reaches the registers over a simple single-cycle bus. Address 0 holds the disable register. Addresses 1 to 8 hold the control registers of modules 0 to 7. Every other address is unmapped.

Top module: `periph_gate_ctrl`

## Requirements
- R1: After reset the disable register and every control register read 0. All clock enables are 1. The functional enable is 1 only for modules without a run bit (default mask 8'h3F: modules 6 and 7 have no run bit).
- R2: A write to address 0 stores wdata[7:0] as the disable bits. From the next cycle on, every module whose bit is set has clock enable 0 and functional enable 0.
- R3: A write to the control register of a module whose disable bit is set is dropped. The register keeps its value.
- R4: A read at address m+1 returns 0 while module m's disable bit is set.
- R5: While a module's disable bit is set, its control register holds its reset value 0. After the bit is cleared, a read of that register returns 0 whatever was stored before.
- R6: Control register bit 0 is the run bit. With the run bit at 0, the clock enable stays 1 and the functional enable is 0. The register remains fully readable and writable.
- R7: For a module without a run bit, control register bit 0 always reads 0, and its functional enable equals its clock enable.
- R8: Control register bit 1 is the idle-stop bit. When idle_i is high and this bit is set, the module's clock enable and functional enable are both 0 in the same cycle. When the bit is clear, idle has no effect.
- R9: A read at address 0 returns the disable bits, zero-extended. A read at an unmapped address (9 to 15) returns 0, and a write there changes no register.
- R10: A module's functional enable is never 1 while its clock enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| idle_i | input | 1 | Device idle indication |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (0 when no read is in progress) |
| mod_clk_en | output | 8 | Per-module clock enable |
| mod_func_en | output | 8 | Per-module functional enable |

## Verification
A bus write updates the registers at the clock edge that ends the access. Both enable vectors reflect the write from that edge on, so they are due one cycle after the write is presented. Read data and the effect of idle_i are combinational: they are due in the same cycle as the stimulus. The driver changes inputs just after a rising edge and queues what it expects. The monitor compares at the following falling edge, which is the earliest point where both the one-cycle and the same-cycle results have settled.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
    localparam int NMOD     = 8;
    localparam int DW       = 16;
    localparam int AW       = $clog2(NMOD + 2);
    localparam int RUN_BIT  = 0;
    localparam int STOP_BIT = 1;

    typedef logic [DW-1:0] ctrl_t;

    typedef struct packed {
        logic [NMOD-1:0]   dis;
        ctrl_t [NMOD-1:0]  ctrl;
    } bank_t;
endpackage

// File: rtl/pgc_regbank.sv
module pgc_regbank
    import pgc_pkg::*;
#(
    parameter logic [NMOD-1:0] HAS_RUN = 8'h3F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    output logic [NMOD-1:0]  dis_q,
    output ctrl_t [NMOD-1:0] ctrl_q
);
    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && addr == '0) begin
            st_d.dis = wdata[NMOD-1:0];
        end
        for (int m = 0; m < NMOD; m++) begin
            if (wr_en && addr == AW'(m + 1) && !st_q.dis[m]) begin
                st_d.ctrl[m] = wdata;
                if (!HAS_RUN[m]) begin
                    st_d.ctrl[m][RUN_BIT] = 1'b0;
                end
            end
            if (st_d.dis[m]) begin
                st_d.ctrl[m] = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dis_q  = st_q.dis;
    assign ctrl_q = st_q.ctrl;
endmodule

// File: rtl/pgc_gate.sv
module pgc_gate
    import pgc_pkg::*;
#(
    parameter logic [NMOD-1:0] HAS_RUN = 8'h3F
) (
    input  logic             idle_i,
    input  logic [NMOD-1:0]  dis,
    input  ctrl_t [NMOD-1:0] ctrl,
    output logic [NMOD-1:0]  clk_en,
    output logic [NMOD-1:0]  func_en
);
    for (genvar m = 0; m < NMOD; m++) begin : g_mod
        logic idle_stop;
        assign idle_stop  = idle_i && ctrl[m][STOP_BIT];
        assign clk_en[m]  = !dis[m] && !idle_stop;
        if (HAS_RUN[m]) begin : g_run
            assign func_en[m] = clk_en[m] && ctrl[m][RUN_BIT];
        end else begin : g_norun
            assign func_en[m] = clk_en[m];
        end
    end
endmodule

// File: rtl/pgc_rdmux.sv
module pgc_rdmux
    import pgc_pkg::*;
(
    input  logic             rd_en,
    input  logic [AW-1:0]    addr,
    input  logic [NMOD-1:0]  dis,
    input  ctrl_t [NMOD-1:0] ctrl,
    output logic [DW-1:0]    rdata
);
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (addr == '0) begin
                rdata = DW'(dis);
            end
            for (int m = 0; m < NMOD; m++) begin
                if (addr == AW'(m + 1) && !dis[m]) begin
                    rdata = ctrl[m];
                end
            end
        end
    end
endmodule

// File: rtl/periph_gate_ctrl.sv
module periph_gate_ctrl
    import pgc_pkg::*;
#(
    parameter logic [NMOD-1:0] HAS_RUN = 8'h3F
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            idle_i,
    input  logic            bus_sel,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic [NMOD-1:0] mod_clk_en,
    output logic [NMOD-1:0] mod_func_en
);
    logic [NMOD-1:0]    dis_q;
    ctrl_t [NMOD-1:0]   ctrl_q;
    logic [NMOD*DW-1:0] ctrl_flat;

    pgc_regbank #(.HAS_RUN(HAS_RUN)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bus_sel && bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .dis_q  (dis_q),
        .ctrl_q (ctrl_q)
    );

    pgc_gate #(.HAS_RUN(HAS_RUN)) u_gate (
        .idle_i  (idle_i),
        .dis     (dis_q),
        .ctrl    (ctrl_q),
        .clk_en  (mod_clk_en),
        .func_en (mod_func_en)
    );

    pgc_rdmux u_rd (
        .rd_en (bus_sel && !bus_wr),
        .addr  (bus_addr),
        .dis   (dis_q),
        .ctrl  (ctrl_q),
        .rdata (bus_rdata)
    );

    assign ctrl_flat = ctrl_q;
endmodule

// File: rtl/pgc_chk.sv
module pgc_chk
    import pgc_pkg::*;
#(
    parameter logic [NMOD-1:0] HAS_RUN = 8'h3F
) (
    input logic               clk,
    input logic               rst_n,
    input logic               idle_i,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic [AW-1:0]      bus_addr,
    input logic [DW-1:0]      bus_wdata,
    input logic [DW-1:0]      bus_rdata,
    input logic [NMOD-1:0]    mod_clk_en,
    input logic [NMOD-1:0]    mod_func_en,
    input logic [NMOD-1:0]    dis_q,
    input logic [NMOD*DW-1:0] ctrl_flat
);
    // R2
    dis_gates_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == '0)
        |=> ((mod_clk_en | mod_func_en) & $past(bus_wdata[NMOD-1:0])) == '0);

    // R3
    blocked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr != '0 && bus_addr <= AW'(NMOD)
         && dis_q[bus_addr - AW'(1)])
        |=> ctrl_flat == $past(ctrl_flat));

    // R4
    blocked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr != '0 && bus_addr <= AW'(NMOD)
         && dis_q[bus_addr - AW'(1)])
        |-> bus_rdata == '0);

    // R9
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr > AW'(NMOD)) |-> bus_rdata == '0);

    // R10
    func_needs_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_func_en & ~mod_clk_en) == '0);

    // R7
    norun_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_func_en & ~HAS_RUN) == (mod_clk_en & ~HAS_RUN));

    for (genvar m = 0; m < NMOD; m++) begin : g_chk
        // R8
        idle_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (idle_i && ctrl_flat[m*DW + STOP_BIT]) |-> !mod_clk_en[m]);
        // R5
        dis_holds_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
            dis_q[m] |-> ctrl_flat[m*DW +: DW] == '0);
    end
endmodule

bind periph_gate_ctrl pgc_chk #(.HAS_RUN(HAS_RUN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .idle_i      (idle_i),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .mod_clk_en  (mod_clk_en),
    .mod_func_en (mod_func_en),
    .dis_q       (dis_q),
    .ctrl_flat   (ctrl_flat)
);

// File: tb/periph_gate_ctrl_bench.sv
module periph_gate_ctrl_bench;
    localparam int K_RD   = 0;
    localparam int K_CLK  = 1;
    localparam int K_FUNC = 2;

    typedef struct {
        int          kind;
        logic [15:0] exp;
        string       req;
    } item_t;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        idle_i = 0;
    logic        bus_sel = 0;
    logic        bus_wr = 0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [7:0]  mod_clk_en;
    logic [7:0]  mod_func_en;

    item_t q[$];
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 0;

    always #5 clk = ~clk;

    periph_gate_ctrl u_periph_gate_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .idle_i      (idle_i),
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .mod_clk_en  (mod_clk_en),
        .mod_func_en (mod_func_en)
    );

    // monitor: compares queued expectations at the falling edge
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [15:0] act;
            it = q.pop_front();
            case (it.kind)
                K_RD:    act = bus_rdata;
                K_CLK:   act = {8'h00, mod_clk_en};
                default: act = {8'h00, mod_func_en};
            endcase
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic expect_item(input int kind, input logic [3:0] a,
                               input logic [15:0] e, input string req);
        item_t it;
        if (kind == K_RD) begin
            bus_sel = 1; bus_wr = 0; bus_addr = a;
        end
        it.kind = kind; it.exp = e; it.req = req;
        q.push_back(it);
        @(posedge clk); #1;
        bus_sel = 0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        expect_item(K_CLK, 0, 16'h00FF, "R1");
        expect_item(K_FUNC, 0, 16'h00C0, "R1");
        expect_item(K_RD, 0, 16'h0000, "R1");
        expect_item(K_RD, 1, 16'h0000, "R1");
        // R6 run bit
        wr(1, 16'hAB01);
        expect_item(K_FUNC, 0, 16'h00C1, "R6");
        wr(1, 16'hAB00);
        expect_item(K_FUNC, 0, 16'h00C0, "R6");
        expect_item(K_CLK, 0, 16'h00FF, "R6");
        expect_item(K_RD, 1, 16'hAB00, "R6");
        // R7 module without run bit
        wr(8, 16'h0003);
        expect_item(K_RD, 8, 16'h0002, "R7");
        expect_item(K_FUNC, 0, 16'h00C0, "R7");
        // R8 idle stop
        wr(2, 16'h0003);
        expect_item(K_FUNC, 0, 16'h00C2, "R8");
        idle_i = 1;
        expect_item(K_CLK, 0, 16'h007D, "R8");
        expect_item(K_FUNC, 0, 16'h0040, "R8");
        idle_i = 0;
        expect_item(K_CLK, 0, 16'h00FF, "R8");
        // R2 hard disable of module 1
        wr(0, 16'h0002);
        expect_item(K_CLK, 0, 16'h00FD, "R2");
        expect_item(K_FUNC, 0, 16'h00C0, "R2");
        expect_item(K_RD, 0, 16'h0002, "R9");
        expect_item(K_RD, 2, 16'h0000, "R4");
        // R3 write to disabled module dropped
        wr(2, 16'h5501);
        expect_item(K_RD, 2, 16'h0000, "R3");
        expect_item(K_FUNC, 0, 16'h00C0, "R3");
        // R5 re-enable starts clean
        wr(0, 16'h0000);
        expect_item(K_RD, 2, 16'h0000, "R5");
        expect_item(K_CLK, 0, 16'h00FF, "R5");
        wr(0, 16'h0001);
        wr(0, 16'h0000);
        expect_item(K_RD, 1, 16'h0000, "R5");
        // R10 enables consistent under idle with a soft-enabled module
        wr(1, 16'h0003);
        idle_i = 1;
        expect_item(K_FUNC, 0, 16'h0040, "R10");
        idle_i = 0;
        // R9 unmapped address
        wr(12, 16'hFFFF);
        expect_item(K_RD, 12, 16'h0000, "R9");
        expect_item(K_RD, 0, 16'h0000, "R9");
        expect_item(K_RD, 1, 16'h0003, "R9");
        @(posedge clk);
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            summary();
            $finish;
        end
    end
endmodule